// File: doc/BRIEF.md
# Interrupt Event Queue Writer

This block is the producer end of a circular in-memory event queue that belongs to one virtual processor. It takes routed interrupt events, each tagged with a logical interrupt number. For each event it issues one 32-bit memory write into the queue buffer, then advances its producer pointer. After the memory side acknowledges the write, it decides whether the owning processor must be told. If the processor is not reachable, the notification can be turned into an escalation interrupt, which has gating state of its own.

Each entry carries a generation bit, so the consumer can tell fresh slots from stale ones after the buffer wraps. Software sets up the queue with one configuration write that supplies the buffer base, the log2 buffer size in bytes, an enable, and two mode flags. The first flag, always-notify, makes every entry notify the processor. The second, escalate, routes failed notifications to the escalation output. Every accepted configuration write restarts the queue with generation 1 at slot 0. A configuration that cannot be honoured is refused and the previous one stays in force.

Top module: `evq_writer`

## Requirements
- R1: Each entry is written as one request at address base + 4*pointer. The data word holds the generation bit in bit 31 and the logical interrupt number in bits 30:0.
- R2: A queue of log2 size S bytes holds 2^(S-2) entries. After the last slot the pointer returns to 0 and the generation bit inverts.
- R3: Every accepted configuration write sets the generation to 1 and the pointer to 0. This includes disabling and re-enabling the queue, and it also holds out of reset.
- R4: An enabling configuration is refused if the base is not aligned to 2^S or if S lies outside QSZ_MIN..QSZ_MAX. A refusal is signalled by a one-cycle pulse on cfg_reject in the cycle after the write, and the old configuration, pointer and generation are kept.
- R5: While the queue is disabled (enable flag 0 or size 0), events are accepted and discarded, and no memory write is issued.
- R6: Only one write is outstanding at a time. Address and data stay stable until mem_ack, and no notification is raised before the write is acknowledged.
- R7: Without always-notify, a queue gate bit pair P/Q controls notification. On a new entry, state 00 goes to 10 and notifies; state 10 or 11 goes to 11 without notifying.
- R8: A q_eoi pulse, when always-notify is off, moves the queue gate from 10 to 00, or from 11 to 10 and notifies again.
- R9: With always-notify set, every acknowledged entry notifies, whatever the gate state.
- R10: A notification that finds vp_online low is lost if escalate is off. If escalate is on, it triggers the escalation gate: 00 goes to 10 with a one-cycle esc_irq pulse, 10 goes to 11 silently, and 01 (masked) is unchanged.
- R11: An esc_eoi pulse moves the escalation gate from 10 to 00, or from 11 to 10 with an esc_irq pulse.
- R12: The escalation gate is forced to 00 by an accepted configuration that enables the queue. It is forced to 01 by one that leaves the queue disabled, and it is 01 out of reset (esc_pq bit 1 = P, bit 0 = Q).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_base | input | ADDR_W | Queue buffer byte address |
| cfg_qsize | input | QSZ_W | log2 of buffer size in bytes, 0 = not populated |
| cfg_enable | input | 1 | Queue enable |
| cfg_always_notify | input | 1 | Notify on every entry, bypassing the queue gate |
| cfg_escalate | input | 1 | Turn failed notifications into escalations |
| cfg_reject | output | 1 | Pulse: last configuration write was refused |
| ev_valid | input | 1 | Routed event present |
| ev_lirq | input | 31 | Logical interrupt number of the event |
| ev_ready | output | 1 | Event can be taken this cycle |
| q_eoi | input | 1 | End-of-interrupt for the queue gate |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 32 | Entry word |
| mem_ack | input | 1 | Memory write completed |
| vp_online | input | 1 | Processor can take a notification |
| ntf_req | output | 1 | Notification request to the processor |
| ntf_ack | input | 1 | Notification taken |
| esc_eoi | input | 1 | End-of-interrupt for the escalation gate |
| esc_irq | output | 1 | One-cycle escalation interrupt pulse |
| esc_pq | output | 2 | Escalation gate state, P in bit 1 |

## Verification
The bench builds the block with QSZ_MIN=3 and QSZ_MAX=8. A 4-entry buffer (S=4) and the 2-entry minimum (S=3) both wrap within a handful of events, so the generation flip is exercised several times in both directions. The small limit also puts an out-of-range size of 9 within the 4-bit size field, so rejection on both ends of the range can be checked alongside misaligned bases. Stalled memory acknowledgements, an offline processor, and every gate transition of both P/Q pairs are driven against a behavioural model.

// File: rtl/evq_pkg.sv
package evq_pkg;

    localparam int ENTRY_W   = 32;
    localparam int LIRQ_W    = ENTRY_W - 1;
    localparam int SLOT_LOG2 = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_NOTIFY = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic              gen;
        logic [LIRQ_W-1:0] lirq;
    } q_entry_t;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    localparam pq_t PQ_OFF    = '{p: 1'b0, q: 1'b0};
    localparam pq_t PQ_MASKED = '{p: 1'b0, q: 1'b1};

endpackage

// File: rtl/evq_pq_gate.sv
module evq_pq_gate
    import evq_pkg::*;
#(
    parameter pq_t RST_PQ = PQ_OFF
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic eoi,
    input  logic force_en,
    input  pq_t  force_val,
    output pq_t  pq,
    output logic fire
);

    pq_t pq_q;
    pq_t pq_d;

    always_comb begin
        pq_d = pq_q;
        fire = 1'b0;
        if (eoi) begin
            if (pq_d.p && pq_d.q) begin
                pq_d = '{p: 1'b1, q: 1'b0};
                fire = 1'b1;
            end else if (pq_d.p) begin
                pq_d = PQ_OFF;
            end
        end
        if (trig) begin
            if (!pq_d.p && !pq_d.q) begin
                pq_d = '{p: 1'b1, q: 1'b0};
                fire = 1'b1;
            end else if (pq_d.p) begin
                pq_d.q = 1'b1;
            end
        end
        if (force_en) begin
            pq_d = force_val;
            fire = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pq_q <= RST_PQ;
        else     pq_q <= pq_d;
    end

    assign pq = pq_q;

endmodule

// File: rtl/evq_qcfg.sv
module evq_qcfg
    import evq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int QSZ_MIN = 3,
    parameter int QSZ_MAX = 16,
    parameter int QSZ_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [QSZ_W-1:0]  cfg_qsize,
    input  logic              cfg_enable,
    input  logic              cfg_always_notify,
    input  logic              cfg_escalate,
    input  logic              adv,
    output logic              active,
    output logic              always_ntf,
    output logic              esc_en,
    output logic [ADDR_W-1:0] slot_addr,
    output logic              gen,
    output logic              apply,
    output logic              apply_active,
    output logic              reject
);

    localparam int PTR_W = QSZ_MAX - SLOT_LOG2;

    logic [ADDR_W-1:0] base_q;
    logic [QSZ_W-1:0]  qsz_q;
    logic              active_q, always_q, esc_q, gen_q, reject_q;
    logic [PTR_W-1:0]  ptr_q;

    logic              range_ok, align_ok;
    logic [ADDR_W-1:0] low_mask;
    logic [PTR_W:0]    span;
    logic              at_last;

    assign apply_active = cfg_enable && (cfg_qsize != '0);
    assign range_ok     = (cfg_qsize >= QSZ_W'(QSZ_MIN)) && (cfg_qsize <= QSZ_W'(QSZ_MAX));
    assign low_mask     = ~({ADDR_W{1'b1}} << cfg_qsize);
    assign align_ok     = (cfg_base & low_mask) == '0;
    assign apply        = cfg_wr && (!apply_active || (range_ok && align_ok));

    assign span    = (PTR_W+1)'(1) << (qsz_q - QSZ_W'(SLOT_LOG2));
    assign at_last = ptr_q == PTR_W'(span - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            qsz_q    <= '0;
            active_q <= 1'b0;
            always_q <= 1'b0;
            esc_q    <= 1'b0;
            ptr_q    <= '0;
            gen_q    <= 1'b1;
            reject_q <= 1'b0;
        end else begin
            reject_q <= cfg_wr && !apply;
            if (apply) begin
                base_q   <= cfg_base;
                qsz_q    <= cfg_qsize;
                active_q <= apply_active;
                always_q <= cfg_always_notify;
                esc_q    <= cfg_escalate;
                ptr_q    <= '0;
                gen_q    <= 1'b1;
            end else if (adv) begin
                if (at_last) begin
                    ptr_q <= '0;
                    gen_q <= ~gen_q;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    assign active     = active_q;
    assign always_ntf = always_q;
    assign esc_en     = esc_q;
    assign gen        = gen_q;
    assign slot_addr  = base_q + ADDR_W'({ptr_q, {SLOT_LOG2{1'b0}}});
    assign reject     = reject_q;

endmodule

// File: rtl/evq_writer.sv
module evq_writer
    import evq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int QSZ_MIN = 3,
    parameter int QSZ_MAX = 16,
    localparam int QSZ_W  = $clog2(QSZ_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [QSZ_W-1:0]   cfg_qsize,
    input  logic               cfg_enable,
    input  logic               cfg_always_notify,
    input  logic               cfg_escalate,
    output logic               cfg_reject,
    input  logic               ev_valid,
    input  logic [LIRQ_W-1:0]  ev_lirq,
    output logic               ev_ready,
    input  logic               q_eoi,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_data,
    input  logic               mem_ack,
    input  logic               vp_online,
    output logic               ntf_req,
    input  logic               ntf_ack,
    input  logic               esc_eoi,
    output logic               esc_irq,
    output logic [1:0]         esc_pq
);

    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    q_entry_t          entry_q;
    logic              eoi_pend_q, esc_irq_q;

    logic              active, always_ntf, esc_en, cur_gen;
    logic              apply, apply_active;
    logic [ADDR_W-1:0] slot_addr;

    logic idle, take, eoi_svc, wr_done;
    logic q_fire, esc_fire, want, go_ntf, go_esc;
    pq_t  q_pq, esc_pq_s;

    assign idle     = state_q == ST_IDLE;
    assign ev_ready = idle && !cfg_wr && !eoi_pend_q;
    assign take     = ev_valid && ev_ready && active;
    assign eoi_svc  = idle && eoi_pend_q && !cfg_wr;
    assign wr_done  = (state_q == ST_WRITE) && mem_ack;

    evq_qcfg #(
        .ADDR_W (ADDR_W),
        .QSZ_MIN(QSZ_MIN),
        .QSZ_MAX(QSZ_MAX),
        .QSZ_W  (QSZ_W)
    ) u_cfg (
        .clk              (clk),
        .rst              (rst),
        .cfg_wr           (cfg_wr),
        .cfg_base         (cfg_base),
        .cfg_qsize        (cfg_qsize),
        .cfg_enable       (cfg_enable),
        .cfg_always_notify(cfg_always_notify),
        .cfg_escalate     (cfg_escalate),
        .adv              (take),
        .active           (active),
        .always_ntf       (always_ntf),
        .esc_en           (esc_en),
        .slot_addr        (slot_addr),
        .gen              (cur_gen),
        .apply            (apply),
        .apply_active     (apply_active),
        .reject           (cfg_reject)
    );

    evq_pq_gate #(.RST_PQ(PQ_OFF)) u_qgate (
        .clk      (clk),
        .rst      (rst),
        .trig     (wr_done && !always_ntf),
        .eoi      (eoi_svc && !always_ntf),
        .force_en (apply),
        .force_val(PQ_OFF),
        .pq       (q_pq),
        .fire     (q_fire)
    );

    assign want   = (wr_done && always_ntf) || q_fire;
    assign go_ntf = want && vp_online;
    assign go_esc = want && !vp_online && esc_en;

    evq_pq_gate #(.RST_PQ(PQ_MASKED)) u_egate (
        .clk      (clk),
        .rst      (rst),
        .trig     (go_esc),
        .eoi      (esc_eoi),
        .force_en (apply),
        .force_val(apply_active ? PQ_OFF : PQ_MASKED),
        .pq       (esc_pq_s),
        .fire     (esc_fire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take)         state_d = ST_WRITE;
                else if (go_ntf)  state_d = ST_NOTIFY;
            end
            ST_WRITE: begin
                if (mem_ack)      state_d = go_ntf ? ST_NOTIFY : ST_IDLE;
            end
            ST_NOTIFY: begin
                if (ntf_ack)      state_d = ST_IDLE;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            entry_q    <= '0;
            eoi_pend_q <= 1'b0;
            esc_irq_q  <= 1'b0;
        end else begin
            state_q    <= state_d;
            esc_irq_q  <= esc_fire;
            eoi_pend_q <= (eoi_pend_q && !eoi_svc && !apply) || q_eoi;
            if (take) begin
                addr_q  <= slot_addr;
                entry_q <= '{gen: cur_gen, lirq: ev_lirq};
            end
        end
    end

    assign mem_req  = state_q == ST_WRITE;
    assign mem_addr = addr_q;
    assign mem_data = entry_q;
    assign ntf_req  = state_q == ST_NOTIFY;
    assign esc_irq  = esc_irq_q;
    assign esc_pq   = esc_pq_s;

endmodule

// File: rtl/evq_writer_chk.sv
module evq_writer_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_data,
    input logic              ntf_req,
    input logic              ntf_ack,
    input logic              esc_irq,
    input logic [1:0]        esc_pq
);

    // R6: a pending write holds its request, address and data
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R6: notification never overlaps an unacknowledged write
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && ntf_req));

    // R1: entries land on 4-byte slots
    a_r1_slot_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R5: new events are taken only while nothing is in flight
    a_r5_ready_when_quiet: assert property (@(posedge clk) disable iff (rst)
        ev_ready |-> !mem_req && !ntf_req);

    // R10: an escalation pulse leaves the escalation gate with P set
    a_r10_pulse_sets_p: assert property (@(posedge clk) disable iff (rst)
        esc_irq |-> esc_pq[1]);

    // R9: an acknowledged notification is dropped on the next cycle
    a_r9_ntf_single: assert property (@(posedge clk) disable iff (rst)
        ntf_req && ntf_ack |=> !ntf_req);

endmodule

bind evq_writer evq_writer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/evq_writer_tb.sv
module evq_writer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int QSZ_MIN    = 3;
    localparam int QSZ_MAX    = 8;
    localparam int QSZ_W      = $clog2(QSZ_MAX + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [QSZ_W-1:0]  cfg_qsize = '0;
    logic              cfg_enable = 0, cfg_always_notify = 0, cfg_escalate = 0;
    logic              cfg_reject;
    logic              ev_valid = 0;
    logic [30:0]       ev_lirq = '0;
    logic              ev_ready;
    logic              q_eoi = 0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_data;
    logic              mem_ack = 0;
    logic              vp_online = 1;
    logic              ntf_req;
    logic              ntf_ack = 0;
    logic              esc_eoi = 0;
    logic              esc_irq;
    logic [1:0]        esc_pq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    longint m_base = 0;
    int     m_qsz = 0, m_ptr = 0;
    bit     m_active = 0, m_always = 0, m_escf = 0, m_gen = 1;
    int     m_pq = 0, m_esc = 1;

    evq_writer #(.ADDR_W(ADDR_W), .QSZ_MIN(QSZ_MIN), .QSZ_MAX(QSZ_MAX)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_base(cfg_base), .cfg_qsize(cfg_qsize),
        .cfg_enable(cfg_enable), .cfg_always_notify(cfg_always_notify),
        .cfg_escalate(cfg_escalate), .cfg_reject(cfg_reject),
        .ev_valid(ev_valid), .ev_lirq(ev_lirq), .ev_ready(ev_ready),
        .q_eoi(q_eoi),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .vp_online(vp_online), .ntf_req(ntf_req), .ntf_ack(ntf_ack),
        .esc_eoi(esc_eoi), .esc_irq(esc_irq), .esc_pq(esc_pq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
                finish_run();
            end
        end
    end

    task automatic do_cfg(input longint base, input int qsz, input bit en,
                          input bit alw, input bit esc, input bit exp_rej, input string tag);
        @(negedge clk);
        cfg_wr = 1; cfg_base = ADDR_W'(base); cfg_qsize = QSZ_W'(qsz);
        cfg_enable = en; cfg_always_notify = alw; cfg_escalate = esc;
        @(negedge clk);
        cfg_wr = 0;
        chk(cfg_reject == exp_rej, tag, "cfg_reject", cfg_reject, exp_rej);
        if (!exp_rej) begin
            m_base = base; m_qsz = qsz; m_active = en && (qsz != 0);
            m_always = alw; m_escf = esc; m_ptr = 0; m_gen = 1; m_pq = 0;
            m_esc = m_active ? 0 : 1;
        end
        chk(esc_pq == 2'(m_esc), "R12", "esc_pq after cfg", esc_pq, m_esc);
    endtask

    // decide notify / escalate per model, then check outputs at this negedge
    task automatic resolve(input bit want, input bit online, input string tag);
        bit exp_ntf, exp_pulse;
        exp_ntf = want && online;
        exp_pulse = 0;
        if (want && !online && m_escf) begin
            if (m_esc == 0) begin m_esc = 2; exp_pulse = 1; end
            else if (m_esc == 2) m_esc = 3;
        end
        chk(ntf_req == exp_ntf, tag, "ntf_req", ntf_req, exp_ntf);
        chk(esc_irq == exp_pulse, "R10", "esc_irq", esc_irq, exp_pulse);
        chk(esc_pq == 2'(m_esc), "R10", "esc_pq", esc_pq, m_esc);
        if (ntf_req) begin
            ntf_ack = 1;
            @(negedge clk);
            ntf_ack = 0;
            chk(!ntf_req, tag, "ntf_req after ack", ntf_req, 0);
        end
    endtask

    task automatic send(input int lirq, input bit online, input int delay, input string tag);
        bit want;
        longint exp_addr;
        logic [31:0] exp_data;
        @(negedge clk);
        vp_online = online;
        ev_valid = 1; ev_lirq = 31'(lirq);
        chk(ev_ready, "R5", "ev_ready", ev_ready, 1);
        @(negedge clk);
        ev_valid = 0;
        if (!m_active) begin
            chk(!mem_req, "R5", "mem_req while disabled", mem_req, 0);
            return;
        end
        exp_addr = m_base + 4 * m_ptr;
        exp_data = {m_gen, 31'(lirq)};
        chk(mem_req, "R6", "mem_req", mem_req, 1);
        chk(mem_addr == ADDR_W'(exp_addr), "R1", "mem_addr", mem_addr, exp_addr);
        chk(mem_data == exp_data, "R1", "mem_data", mem_data, exp_data);
        m_ptr++;
        if (m_ptr == (1 << (m_qsz - 2))) begin m_ptr = 0; m_gen = !m_gen; end
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk(mem_req && mem_addr == ADDR_W'(exp_addr) && mem_data == exp_data && !ntf_req,
                "R6", "held request", mem_addr, exp_addr);
        end
        mem_ack = 1;
        @(negedge clk);
        mem_ack = 0;
        if (m_always) want = 1;
        else if (m_pq == 0) begin m_pq = 2; want = 1; end
        else begin if (m_pq >= 2) m_pq = 3; want = 0; end
        resolve(want, online, tag);
    endtask

    task automatic do_qeoi(input bit online, input string tag);
        bit want;
        @(negedge clk);
        vp_online = online;
        q_eoi = 1;
        @(negedge clk);
        q_eoi = 0;
        @(negedge clk);
        want = 0;
        if (!m_always) begin
            if (m_pq == 3) begin m_pq = 2; want = 1; end
            else if (m_pq == 2) m_pq = 0;
        end
        resolve(want, online, tag);
    endtask

    task automatic do_esc_eoi();
        bit exp_pulse;
        @(negedge clk);
        esc_eoi = 1;
        @(negedge clk);
        esc_eoi = 0;
        exp_pulse = 0;
        if (m_esc == 3) begin m_esc = 2; exp_pulse = 1; end
        else if (m_esc == 2) m_esc = 0;
        chk(esc_irq == exp_pulse, "R11", "esc_irq", esc_irq, exp_pulse);
        chk(esc_pq == 2'(m_esc), "R11", "esc_pq", esc_pq, m_esc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!mem_req && !ntf_req, "R6", "idle after reset", {mem_req, ntf_req}, 0);
        chk(esc_pq == 2'b01, "R12", "esc_pq reset", esc_pq, 1);
        chk(ev_ready, "R5", "ev_ready reset", ev_ready, 1);
        chk(!esc_irq && !cfg_reject, "R4", "no pulses at reset", {esc_irq, cfg_reject}, 0);

        // R5: disabled out of reset
        send(7, 1, 0, "R5");

        // R4: misaligned and out-of-range enabling configs refused
        do_cfg(64'h1008, 4, 1, 0, 1, 1, "R4");
        do_cfg(64'h1010, 5, 1, 0, 1, 1, "R4");
        do_cfg(64'h1000, 2, 1, 0, 1, 1, "R4");
        do_cfg(64'h1000, 9, 1, 0, 1, 1, "R4");
        send(8, 1, 0, "R5");

        // R3 R7 R8 R2: gated mode, 4-entry queue
        do_cfg(64'h1000, 4, 1, 0, 1, 0, "R3");
        send(32'h11, 1, 0, "R7");
        send(32'h12, 1, 2, "R7");
        do_qeoi(1, "R8");
        do_qeoi(1, "R8");
        send(32'h13, 1, 0, "R7");
        send(32'h14, 1, 0, "R7");
        send(32'h7fff_ffff, 1, 1, "R2");
        // R4: refusal keeps pointer and generation
        do_cfg(64'h2004, 4, 1, 0, 1, 1, "R4");
        send(32'h15, 1, 0, "R4");
        do_qeoi(1, "R8");
        do_qeoi(1, "R8");
        // R3: rewrite restarts at slot 0 with generation 1
        do_cfg(64'h1000, 4, 1, 0, 1, 0, "R3");
        send(32'h16, 1, 0, "R3");

        // R2: minimum size, two entries, several wraps
        do_cfg(64'h0040, 3, 1, 1, 0, 0, "R2");
        for (int i = 0; i < 5; i++) send(32'h20 + i, 1, 0, "R2");

        // R9 R10 R11: always-notify with escalation
        do_cfg(64'h3000, 5, 1, 1, 1, 0, "R9");
        send(32'h31, 1, 0, "R9");
        send(32'h32, 1, 0, "R9");
        send(32'h33, 0, 0, "R10");
        send(32'h34, 0, 0, "R10");
        do_esc_eoi();
        do_esc_eoi();
        do_esc_eoi();
        send(32'h35, 0, 0, "R10");

        // R12: disable masks escalation; events then dropped
        do_cfg(64'h3000, 5, 0, 1, 1, 0, "R12");
        send(32'h36, 0, 0, "R5");
        do_esc_eoi();
        // size zero with enable set stays disabled
        do_cfg(64'h3000, 0, 1, 1, 1, 0, "R5");
        send(32'h37, 1, 0, "R5");
        // R3: re-enable restarts generation and pointer
        do_cfg(64'h3000, 5, 1, 1, 1, 0, "R3");
        send(32'h38, 1, 0, "R3");

        // R10: escalate off, offline notification lost
        do_cfg(64'h4000, 4, 1, 1, 0, 0, "R10");
        send(32'h41, 0, 0, "R10");
        send(32'h42, 1, 0, "R9");

        // R10: gated mode, offline, escalate on
        do_cfg(64'h5000, 4, 1, 0, 1, 0, "R10");
        send(32'h51, 0, 0, "R10");
        send(32'h52, 0, 0, "R7");
        do_qeoi(0, "R8");
        do_esc_eoi();

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule